// File: doc/BRIEF.md
# Two-Tally Position Accumulator

This block keeps a signed position from two streams of count strobes. One stream means "one step forward" and the other means "one step back". Each stream drives its own free-running binary tally, and the position word is the forward tally minus the reverse tally, formed by a subtractor. Both strobes are active low. A strobe counts in every rising clock edge at which it is low.

It sits after a direction-resolving front end, for example a quadrature decoder, and gives a position word that grows while the mechanism moves forward and shrinks while it moves backward. A synchronous clear sets the origin. The tallies wrap modulo 2^W. In two's complement the difference stays exact even after either tally has wrapped.

Top module: `pos_accum`

## Requirements
- R1: While `rst` is high at a rising edge, both tallies return to zero, and `pos` reads 0 after that edge.
- R2: An edge with `up_n` low, `dn_n` high and `clr` low makes `pos` one greater after that edge, modulo 2^W.
- R3: An edge with `dn_n` low, `up_n` high and `clr` low makes `pos` one smaller after that edge, modulo 2^W.
- R4: An edge with both strobes low, or both strobes high, and `clr` low leaves `pos` unchanged.
- R5: An edge with `clr` high makes `pos` read 0 after that edge, whatever the strobes are in that cycle.
- R6: The position stays equal to (forward count minus reverse count) mod 2^W after the forward tally has wrapped past 2^W. For example, 65540 forward steps from 0 read 4 when W is 16.
- R7: Going below zero is shown in two's complement. One reverse step from 0 reads all ones (0xFFFF for W = 16), and a forward step from 0x7FFF reads 0x8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous origin clear, active high, takes priority over the strobes |
| up_n | input | 1 | Forward step strobe, active low |
| dn_n | input | 1 | Reverse step strobe, active low |
| pos | output | W (16) | Position word, two's complement, forward tally minus reverse tally |

## Verification
The tallies are the only state, so a wrong tally shows at the port as a `pos` value that is off by a fixed amount. That offset appears right after the edge that introduced it and persists until the next clear. The bench compares `pos` against a reference model after every edge, so a miscount, a lost step, or a clear that fails to take priority is caught in the same cycle. A fault that appears only when a tally carries out of its top bit shows up only after the long forward run past 2^W.

// File: rtl/pos_acc_pkg.sv
package pos_acc_pkg;

    parameter int unsigned POS_W = 16;
    localparam int unsigned N_TALLY = 2;
    localparam int unsigned IDX_FWD = 0;
    localparam int unsigned IDX_REV = 1;

    // Action a tally takes at the next rising edge
    typedef enum logic [1:0] {
        OP_KEEP = 2'd0,
        OP_STEP = 2'd1,
        OP_ZERO = 2'd2
    } tally_op_e;

    // Decoded, active-high step requests
    typedef struct packed {
        logic rev;
        logic fwd;
    } step_req_t;

    // Zeroing wins over a step; otherwise a step request advances the tally
    function automatic tally_op_e pick_op(input logic zero, input logic hit);
        if (zero)
            return OP_ZERO;
        else if (hit)
            return OP_STEP;
        else
            return OP_KEEP;
    endfunction

    // Strobes are active low
    function automatic step_req_t decode_strobes(input logic up_n, input logic dn_n);
        step_req_t r;
        r.fwd = ~up_n;
        r.rev = ~dn_n;
        return r;
    endfunction

endpackage

// File: rtl/pos_tally.sv
module pos_tally #(
    parameter int unsigned W = pos_acc_pkg::POS_W
) (
    input  logic         clk,
    input  logic         zero,
    input  logic         hit,
    output logic [W-1:0] count
);
    import pos_acc_pkg::*;

    tally_op_e op;
    logic [W-1:0] count_q;

    assign op = pick_op(zero, hit);

    always_ff @(posedge clk) begin
        unique case (op)
            OP_ZERO: count_q <= '0;
            OP_STEP: count_q <= count_q + W'(1);
            default: count_q <= count_q;
        endcase
    end

    assign count = count_q;
endmodule

// File: rtl/pos_subtract.sv
module pos_subtract #(
    parameter int unsigned W = pos_acc_pkg::POS_W
) (
    input  logic [W-1:0] minuend,
    input  logic [W-1:0] subtrahend,
    output logic [W-1:0] diff
);
    // Modulo-2^W difference; two's complement keeps it exact across wrap
    assign diff = minuend - subtrahend;
endmodule

// File: rtl/pos_accum.sv
module pos_accum #(
    parameter int unsigned W = pos_acc_pkg::POS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         up_n,
    input  logic         dn_n,
    output logic [W-1:0] pos
);
    import pos_acc_pkg::*;

    step_req_t              req;
    logic                   zero_all;
    logic [N_TALLY-1:0]     hits;
    logic [N_TALLY-1:0][W-1:0] tallies;

    assign req      = decode_strobes(up_n, dn_n);
    assign zero_all = rst | clr;

    always_comb begin
        hits          = '0;
        hits[IDX_FWD] = req.fwd;
        hits[IDX_REV] = req.rev;
    end

    for (genvar g = 0; g < N_TALLY; g++) begin : g_tally
        pos_tally #(.W(W)) u_tally (
            .clk   (clk),
            .zero  (zero_all),
            .hit   (hits[g]),
            .count (tallies[g])
        );
    end

    pos_subtract #(.W(W)) u_sub (
        .minuend    (tallies[IDX_FWD]),
        .subtrahend (tallies[IDX_REV]),
        .diff       (pos)
    );
endmodule

// File: rtl/pos_accum_chk.sv
module pos_accum_chk #(
    parameter int unsigned W = pos_acc_pkg::POS_W
) (
    input logic         clk,
    input logic         rst,
    input logic         clr,
    input logic         up_n,
    input logic         dn_n,
    input logic [W-1:0] pos
);
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (pos == '0));

    p_fwd_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!clr && !up_n && dn_n) |=> (pos == W'($past(pos) + W'(1))));

    p_rev_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr && up_n && !dn_n) |=> (pos == W'($past(pos) - W'(1))));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!clr && (up_n == dn_n)) |=> $stable(pos));

    p_clear_wins_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pos == '0));

    p_below_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (!clr && up_n && !dn_n && (pos == '0)) |=> (pos == '1));
endmodule

bind pos_accum pos_accum_chk #(.W(W)) u_pos_accum_chk (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .up_n (up_n),
    .dn_n (dn_n),
    .pos  (pos)
);

// File: tb/test_pos_accum.sv
`timescale 1ns/1ps
module test_pos_accum;
    localparam int unsigned W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr = 1'b0;
    logic         up_n = 1'b1;
    logic         dn_n = 1'b1;
    logic [W-1:0] pos;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] model = '0;

    always #2.5 clk = ~clk;

    pos_accum #(.W(W)) i_pos_accum (
        .clk(clk), .rst(rst), .clr(clr), .up_n(up_n), .dn_n(dn_n), .pos(pos)
    );

    function automatic logic [W-1:0] next_pos(input logic [W-1:0] p, input logic r,
                                              input logic c, input logic u_n, input logic d_n);
        if (r || c) return '0;
        if (!u_n && d_n) return p + W'(1);
        if (u_n && !d_n) return p - W'(1);
        return p;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] exp);
        checks++;
        if (pos !== exp) begin
            errors++;
            $display("FAIL %s pos=%h expected=%h", tag, pos, exp);
        end
    endtask

    // drive at negedge, let one rising edge pass, compare afterwards
    task automatic step(input logic r, input logic c, input logic u_n, input logic d_n,
                        input string tag, input bit do_check);
        @(negedge clk);
        rst = r; clr = c; up_n = u_n; dn_n = d_n;
        @(posedge clk);
        model = next_pos(model, r, c, u_n, d_n);
        #1;
        if (do_check) check(tag, model);
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        step(1, 0, 0, 0, "R1 reset", 1);
        step(1, 0, 0, 1, "R1 reset ignores strobes", 1);
        // R2: forward steps
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R2 forward", 1);
        // R4: both low, both high
        step(0, 0, 0, 0, "R4 both low", 1);
        step(0, 0, 1, 1, "R4 none", 1);
        // R3: reverse steps
        for (int i = 0; i < 2; i++) step(0, 0, 1, 0, "R3 reverse", 1);
        // R5: clear beats strobes
        step(0, 1, 0, 1, "R5 clear with forward", 1);
        step(0, 1, 1, 0, "R5 clear with reverse", 1);
        // R7: below zero
        step(0, 0, 1, 0, "R7 below zero", 1);
        check("R7 all ones", '1);
        step(0, 1, 1, 1, "R5 clear", 1);
        for (int i = 0; i < 32767; i++) step(0, 0, 0, 1, "R2 climb", 0);
        check("R7 at 7fff", 16'h7fff);
        step(0, 0, 0, 1, "R7 to 8000", 1);
        check("R7 8000", 16'h8000);
        // R6: forward tally wraps
        step(0, 1, 1, 1, "R5 clear", 1);
        for (int i = 0; i < 65540; i++) step(0, 0, 0, 1, "R6 long run", 0);
        check("R6 after wrap", 16'd4);
        for (int i = 0; i < 6; i++) step(0, 0, 1, 0, "R6 reverse after wrap", 1);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic c;
            c = ($urandom % 20) == 0;
            step(0, c, 1'($urandom), 1'($urandom), "R2/R3/R4/R5 random", 1);
        end
        // R1: reset mid-run
        step(0, 0, 0, 1, "R2 forward", 1);
        step(1, 0, 0, 1, "R1 mid reset", 1);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 pos=%h expected=run to complete", pos);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule